// File: doc/BRIEF.md
# Bidirectional GPIO Port with Pull-ups

This block is an 8-pin general-purpose I/O port that software reaches through a small register bus. Each pin owns a direction bit and a drive/pull bit, both held in registers. The port also offers a synchronized sample of the raw pad level. The block feeds an output enable, a drive level and a pull-up enable to each pad model, and it takes the raw pad level back in.

The drive/pull bit has two jobs. On a pin set as an output it is the level driven onto the pad. On a pin set as an input it switches on the weak pull-up. A chip-wide pull-up kill input overrides every pull-up. An asynchronous reset returns every pin to high impedance with no pull, and it does so whether or not the clock is running. Pad levels cross into the clock domain through a two-flop synchronizer. A chip-wide sleep input forces the sampled levels to read as zero.

Top module: `gpioPort`

## Requirements
- R1: While `rstN` is low, with or without a clock edge, both stored registers clear and `padOe`, `padOut` and `padPullEn` are all zero.
- R2: A write (`wrEn` high at a clock edge) to address 0 loads `wrData` into the direction register. A read (`rdEn` high) of address 0 returns it in the same cycle.
- R3: A write to address 1 loads the drive/pull register. A read of address 1 returns the stored bits and not the pad level.
- R4: For each pin, `padOe` equals its direction bit. `padOut` equals its drive/pull bit when the direction bit is 1, and is 0 otherwise.
- R5: For each pin, `padPullEn` is 1 exactly when its direction bit is 0, its drive/pull bit is 1 and `pullDisable` is 0.
- R6: While `pullDisable` is 1, every bit of `padPullEn` is 0, and the stored registers keep their values.
- R7: A read of address 2 returns `padIn` as it stood two clock edges earlier. A change on `padIn` is not visible after one edge and is visible after the second.
- R8: Address 2 returns the sampled pad levels for output pins as well as input pins.
- R9: While `sleep` is 1, a read of address 2 returns 0 on every bit.
- R10: Writes to address 2 or 3 change neither stored register. A read of address 3 returns 0, and `rdData` is 0 while `rdEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register address: 0 direction, 1 drive/pull, 2 pin sample |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | 8 | Read data, combinational, zero when not reading |
| pullDisable | input | 1 | Chip-wide pull-up kill |
| sleep | input | 1 | Chip-wide sleep, blanks the input sample |
| padIn | input | 8 | Raw pad levels |
| padOe | output | 8 | Per-pin output enable |
| padOut | output | 8 | Per-pin drive level |
| padPullEn | output | 8 | Per-pin pull-up enable |

## Verification
The assertions watch, on every cycle, that a pull-up is never enabled on a driven pin or under the global kill. They also check that a register changes only on its own write strobe, that the pin sample lags the pads by exactly two edges and is blanked in sleep, and that at most one read source is selected. Only the bench's scenarios show that the full truth table of direction, drive/pull and kill maps to the pad signals for every pattern. The scenarios also show that a pad change is invisible after one edge, and that reset clears the pins between clock edges with no edge at all.

// File: rtl/gpioPkg.sv
package gpioPkg;
  typedef struct packed {
    logic wrDir;
    logic wrOut;
    logic rdDir;
    logic rdOut;
    logic rdIn;
  } regStrb_t;
endpackage

// File: rtl/gpioCtrl.sv
module gpioCtrl
  import gpioPkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int DIR_ADDR = 0,
  parameter int OUT_ADDR = 1,
  parameter int IN_ADDR  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output regStrb_t          strb
);
  localparam logic [ADDR_W-1:0] DirA = ADDR_W'(DIR_ADDR);
  localparam logic [ADDR_W-1:0] OutA = ADDR_W'(OUT_ADDR);
  localparam logic [ADDR_W-1:0] InA  = ADDR_W'(IN_ADDR);

  always_comb begin
    strb       = '0;
    strb.wrDir = wrEn && (addr == DirA);
    strb.wrOut = wrEn && (addr == OutA);
    strb.rdDir = rdEn && (addr == DirA);
    strb.rdOut = rdEn && (addr == OutA);
    strb.rdIn  = rdEn && (addr == InA);
  end

  // R10: at most one read source selected at a time
  assert_one_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.rdDir, strb.rdOut, strb.rdIn}));
  // R10: the pin-sample address never raises a register write strobe
  assert_in_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == InA) |-> !(strb.wrDir || strb.wrOut));
endmodule

// File: rtl/gpioDatapath.sv
module gpioDatapath
  import gpioPkg::*;
#(
  parameter int PIN_COUNT = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStrb_t             strb,
  input  logic [PIN_COUNT-1:0] wrData,
  input  logic                 pullDisable,
  input  logic                 sleep,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] rdData,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padPullEn
);
  localparam int SYNC_DEPTH = 2;

  logic [PIN_COUNT-1:0] dirReg;
  logic [PIN_COUNT-1:0] outReg;
  logic [PIN_COUNT-1:0] syncStage [SYNC_DEPTH];
  logic [PIN_COUNT-1:0] pinVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirReg <= '0;
      outReg <= '0;
    end else begin
      if (strb.wrDir) dirReg <= wrData;
      if (strb.wrOut) outReg <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < SYNC_DEPTH; k++) syncStage[k] <= '0;
    end else begin
      syncStage[0] <= padIn;
      for (int k = 1; k < SYNC_DEPTH; k++) syncStage[k] <= syncStage[k-1];
    end
  end

  assign pinVal = sleep ? '0 : syncStage[SYNC_DEPTH-1];

  for (genvar i = 0; i < PIN_COUNT; i++) begin : gPin
    assign padOe[i]     = dirReg[i];
    assign padOut[i]    = dirReg[i] & outReg[i];
    assign padPullEn[i] = ~dirReg[i] & outReg[i] & ~pullDisable;
  end

  always_comb begin
    rdData = '0;
    if (strb.rdDir)      rdData = dirReg;
    else if (strb.rdOut) rdData = outReg;
    else if (strb.rdIn)  rdData = pinVal;
  end

  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                sinceRst <= '0;
    else if (sinceRst != 2'd2) sinceRst <= sinceRst + 2'd1;
  end

  // R5: no pull-up on a driven pin
  assert_pull_vs_drive_R5: assert property (@(posedge clk) disable iff (!rstN)
    (padPullEn & padOe) == '0);
  // R6: global kill removes every pull-up
  assert_pull_kill_R6: assert property (@(posedge clk) disable iff (!rstN)
    pullDisable |-> padPullEn == '0);
  // R2: direction register loads on its strobe, holds otherwise
  assert_dir_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrDir |=> dirReg == $past(wrData));
  assert_dir_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrDir |=> $stable(dirReg));
  // R3: drive/pull register holds without its strobe
  assert_out_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrOut |=> $stable(outReg));
  // R7: sample lags pads by two edges
  assert_sync_lag_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd2) |-> syncStage[SYNC_DEPTH-1] == $past(padIn, 2));
  // R9: sleep blanks the pin read
  assert_sleep_blank_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdIn && sleep) |-> rdData == '0);
endmodule

// File: rtl/gpioPort.sv
module gpioPort
  import gpioPkg::*;
#(
  parameter int PIN_COUNT = 8,
  parameter int ADDR_W    = 2,
  parameter int DIR_ADDR  = 0,
  parameter int OUT_ADDR  = 1,
  parameter int IN_ADDR   = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wrEn,
  input  logic [PIN_COUNT-1:0] wrData,
  input  logic                 rdEn,
  output logic [PIN_COUNT-1:0] rdData,
  input  logic                 pullDisable,
  input  logic                 sleep,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padPullEn
);
  regStrb_t strb;

  gpioCtrl #(
    .ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR), .OUT_ADDR(OUT_ADDR), .IN_ADDR(IN_ADDR)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .strb(strb)
  );

  gpioDatapath #(.PIN_COUNT(PIN_COUNT)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .pullDisable(pullDisable), .sleep(sleep), .padIn(padIn),
    .rdData(rdData), .padOe(padOe), .padOut(padOut), .padPullEn(padPullEn)
  );
endmodule

// File: tb/sim_gpioPort.sv
module sim_gpioPort;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] addr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic       pullDisable = 1'b0;
  logic       sleep = 1'b0;
  logic [7:0] padIn = '0;
  logic [7:0] padOe, padOut, padPullEn;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpioPort u0 (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .pullDisable(pullDisable), .sleep(sleep),
    .padIn(padIn), .padOe(padOe), .padOut(padOut), .padPullEn(padPullEn)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // read in the current low phase, no clock edge consumed
  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; rdEn = 1'b1;
    #3 d = rdData;
    rdEn = 1'b0;
    #1;
  endtask

  task automatic padCheck(input logic [7:0] dir, input logic [7:0] outv, input logic kill);
    chk("R4 padOe", padOe, dir);
    chk("R4 padOut", padOut, dir & outv);
    chk(kill ? "R6 padPullEn" : "R5 padPullEn", padPullEn, ~dir & outv & {8{~kill}});
  endtask

  initial begin
    logic [7:0] v;
    logic [7:0] pats [4];
    repeat (3) @(negedge clk);
    chk("R1 padOe in reset", padOe, 8'h00);
    chk("R1 padPullEn in reset", padPullEn, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    rd(2'd0, v); chk("R1 dir after reset", v, 8'h00);
    rd(2'd1, v); chk("R1 out after reset", v, 8'h00);
    rd(2'd0, v); chk("R10 rdEn low gives 0", rdData, 8'h00);

    // R2 R3 R4 R5 R6: sweep all direction patterns
    for (int d = 0; d < 256; d++) begin
      pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'(d) ^ 8'h3C;
      for (int p = 0; p < 4; p++) begin
        for (int k = 0; k < 2; k++) begin
          wr(2'd0, 8'(d));
          wr(2'd1, pats[p]);
          pullDisable = k[0];
          #1;
          rd(2'd0, v); chk("R2 dir readback", v, 8'(d));
          rd(2'd1, v); chk("R3 out readback", v, pats[p]);
          padCheck(8'(d), pats[p], k[0]);
        end
      end
    end
    pullDisable = 1'b0;

    // R3: readback ignores pads
    wr(2'd0, 8'h00); wr(2'd1, 8'h5A);
    padIn = 8'hFF;
    repeat (3) @(negedge clk);
    rd(2'd1, v); chk("R3 out not pad", v, 8'h5A);

    // R7 R8: two-edge latency over every pad value, half the pins driven
    wr(2'd0, 8'hF0);
    for (int p = 0; p < 256; p++) begin
      logic [7:0] prev;
      @(negedge clk);
      prev = padIn;
      padIn = 8'(p);
      @(negedge clk);
      rd(2'd2, v); chk("R7 not after one edge", v, prev);
      @(negedge clk);
      rd(2'd2, v); chk("R7 R8 after two edges", v, 8'(p));
    end

    // R9: sleep blanks, wake restores
    padIn = 8'hC3;
    repeat (3) @(negedge clk);
    sleep = 1'b1;
    #1;
    rd(2'd2, v); chk("R9 sleep reads zero", v, 8'h00);
    @(negedge clk);
    rd(2'd2, v); chk("R9 sleep still zero", v, 8'h00);
    sleep = 1'b0;
    #1;
    rd(2'd2, v); chk("R9 wake reads pads", v, 8'hC3);

    // R10: writes to addresses 2 and 3 are ignored
    wr(2'd0, 8'h3C); wr(2'd1, 8'h96);
    wr(2'd2, 8'h00); wr(2'd3, 8'hFF);
    rd(2'd0, v); chk("R10 dir unchanged", v, 8'h3C);
    rd(2'd1, v); chk("R10 out unchanged", v, 8'h96);
    padCheck(8'h3C, 8'h96, 1'b0);
    rd(2'd3, v); chk("R10 addr3 reads zero", v, 8'h00);

    // R1: asynchronous reset between edges
    wr(2'd0, 8'h0F); wr(2'd1, 8'hFF);
    @(posedge clk); #4;
    rstN = 1'b0;
    #2;
    chk("R1 async padOe", padOe, 8'h00);
    chk("R1 async padOut", padOut, 8'h00);
    chk("R1 async padPullEn", padPullEn, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    rd(2'd1, v); chk("R1 out cleared", v, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule